// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block holds the digital side of a 12-bit successive-approximation converter that sits on a processor-style parallel bus. Five control lines select what happens: a chip enable, an active-low select, a read/convert line, a word-width line and a byte-select line. The combination enable high, select low and read/convert low starts a conversion. The conversion starts on the cycle that combination first becomes true, whichever line completed it. The byte-select line, taken at that moment, chooses a full 12-bit cycle or a shortened 8-bit cycle.

During a conversion the sequencer tests one bit per clock, most significant first, against a single comparator input that the analog front end (outside this block) provides. A busy flag is high for exactly the bit-cycles of the conversion. While busy is high the data bus stays released. When it is idle, a read presents either the whole result or one of two left-justified byte views. A new start during a conversion does not restart it, but it does take the byte-select line again. That can lengthen or shorten the conversion already running.

The tri-state bus is modelled as a data vector plus a per-bit enable vector. All control lines pass through a synchroniser of `SYNC_STAGES` flops, 2 by default.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A conversion starts when the synchronised condition chip_en=1, chip_sel_n=0, read_conv=0 goes from false to true. Any one of the three lines may be the last to change, and all three may change together. busy rises within 4 clocks of the change at the pins.
- R2: If the start condition stays true after a conversion ends, no further conversion starts.
- R3: byte_sel is sampled at the start. byte_sel=0 makes busy high for exactly 12 clocks and byte_sel=1 makes it high for exactly 8 clocks.
- R4: While busy is high, dbus_oe is all zero, even when a read is requested.
- R5: A start condition that arises while busy is high does not restart the conversion, but it samples byte_sel again. Switching to 1 early in a 12-bit conversion ends it after 8 bit-cycles. Switching to 0 early in an 8-bit conversion extends it to 12.
- R6: The result bit for each tested position equals the comparator input (1 keeps the trial bit) in the clock after that bit is tried, most significant bit first. After an 8-bit conversion, result bits 3:0 are 0.
- R7: A read is chip_en=1, chip_sel_n=0, read_conv=1 with busy low. With word_mode=1 the bus drives the full 12-bit result and dbus_oe is all ones.
- R8: A read with word_mode=0 and byte_sel=0 drives result bits 11:4 on dbus[11:4] with dbus_oe = 12'hFF0.
- R9: A read with word_mode=0 and byte_sel=1 drives result bits 3:0 on dbus[11:8] and zeros on dbus[7:4], with dbus_oe = 12'hFF0.
- R10: With chip_en=0 or chip_sel_n=1, no conversion starts and dbus_oe is all zero.
- R11: Reset clears busy, the result and the sampled byte_sel, so a full-word read after reset returns 0.
- R12: Whenever dbus_oe is all zero, dbus is all zero. dbus_oe only ever takes the values all zero, all ones or 12'hFF0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| read_conv | input | 1 | 1 = read, 0 = convert |
| word_mode | input | 1 | 1 = full-word read, 0 = byte reads |
| byte_sel | input | 1 | Conversion length at start; byte half on a byte read |
| cmp_hi | input | 1 | Comparator decision for the current trial bit |
| busy | output | 1 | High while a conversion is running |
| dbus | output | 12 | Read data |
| dbus_oe | output | 12 | Per-bit output enable of dbus |

## Verification
The bench sweeps all 64 transitions between pairs of states of the three start lines and expects a start exactly where the condition rises. A design that triggered on a single line, or on a level, would start in the wrong cases or start again on a held condition. A second start issued mid-conversion must change the measured busy length both ways, 12 to 8 and 8 to 12. A design that ignored the late sample, or restarted, would give a length of 12 or a length near 20. Every target code is read in the three bus views. A swapped nibble, a missing zero pad or unmasked low bits after an 8-bit conversion would show up as a miscompare.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

   typedef struct packed {
      logic en;      // chip enable, active high
      logic sel_n;   // chip select, active low
      logic rd;      // 1 = read, 0 = convert
      logic word;    // 1 = full-word read
      logic half;    // length select / byte half select
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   function automatic logic is_start(input ctl_t c);
      return c.en & ~c.sel_n & ~c.rd;
   endfunction

   function automatic logic is_read(input ctl_t c);
      return c.en & ~c.sel_n & c.rd;
   endfunction

endpackage

// File: rtl/sar_ctl_sync.sv
module sar_ctl_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("sar_ctl_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("sar_ctl_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/sar_start_det.sv
module sar_start_det
   import sar_bus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  ctl_t ctl,
   output logic start_p,
   output logic rd_en
);

   logic cond_now;
   logic cond_q;

   assign cond_now = is_start(ctl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond_now;
   end

   // rising edge of the combined condition: whichever line arrives last fires it
   assign start_p = cond_now & ~cond_q;
   assign rd_en   = is_read(ctl);

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_p,
   input  logic             half,
   input  logic             cmp_hi,
   output logic             busy,
   output logic [RES_W-1:0] result
);

   localparam int IW    = $clog2(RES_W);
   localparam int LSB_W = RES_W - SHORT_W;
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};
   localparam logic [RES_W-1:0] HI_MASK = {{SHORT_W{1'b1}}, {LSB_W{1'b0}}};

   if (SHORT_W < 1 || SHORT_W >= RES_W) begin : g_bad_short
      $error("sar_seq: SHORT_W must lie between 1 and RES_W-1");
   end

   logic [IW-1:0]    idx;
   logic             len8;
   logic [RES_W-1:0] sar_q;
   logic [RES_W-1:0] sar_nxt;
   logic [IW-1:0]    last_idx;
   logic             last_bit;

   assign last_idx = len8 ? IW'(LSB_W) : '0;
   // a late switch to the short length may find idx already below the limit
   assign last_bit = (idx <= last_idx);

   always_comb begin
      sar_nxt      = sar_q;
      sar_nxt[idx] = cmp_hi;
      if (last_bit) begin
         if (len8) sar_nxt = sar_nxt & HI_MASK;
      end else begin
         sar_nxt[idx - IW'(1)] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         len8  <= 1'b0;
         sar_q <= '0;
      end else begin
         // every start event samples the length select, even mid-conversion
         if (start_p) len8 <= half;
         if (!busy) begin
            if (start_p) begin
               busy  <= 1'b1;
               idx   <= IW'(RES_W - 1);
               sar_q <= TOP_BIT;
            end
         end else begin
            sar_q <= sar_nxt;
            if (last_bit) busy <= 1'b0;
            else          idx  <= idx - IW'(1);
         end
      end
   end

   assign result = sar_q;

endmodule

// File: rtl/sar_rd_mux.sv
module sar_rd_mux #(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             rd_en,
   input  logic             word,
   input  logic             half,
   input  logic             busy,
   input  logic [RES_W-1:0] result,
   output logic [RES_W-1:0] dbus,
   output logic [RES_W-1:0] dbus_oe
);

   localparam int LSB_W = RES_W - SHORT_W;
   localparam logic [RES_W-1:0] ALL_OE = '1;
   localparam logic [RES_W-1:0] HI_OE  = {{SHORT_W{1'b1}}, {LSB_W{1'b0}}};

   if (LSB_W < 1 || LSB_W > SHORT_W) begin : g_bad_lanes
      $error("sar_rd_mux: low part must fit in the upper byte lane");
   end

   logic [RES_W-1:0] hi_view;
   logic [RES_W-1:0] lo_view;

   assign hi_view = result & HI_OE;
   assign lo_view = {result[LSB_W-1:0], {SHORT_W{1'b0}}};

   always_comb begin
      dbus    = '0;
      dbus_oe = '0;
      if (rd_en && !busy) begin
         if (word) begin
            dbus    = result;
            dbus_oe = ALL_OE;
         end else if (!half) begin
            dbus    = hi_view;
            dbus_oe = HI_OE;
         end else begin
            dbus    = lo_view;
            dbus_oe = HI_OE;
         end
      end
   end

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
   import sar_bus_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             chip_sel_n,
   input  logic             read_conv,
   input  logic             word_mode,
   input  logic             byte_sel,
   input  logic             cmp_hi,
   output logic             busy,
   output logic [RES_W-1:0] dbus,
   output logic [RES_W-1:0] dbus_oe
);

   ctl_t             ctl_raw;
   ctl_t             ctl_s;
   logic             start_p;
   logic             rd_en;
   logic [RES_W-1:0] result;

   assign ctl_raw = '{en: chip_en, sel_n: chip_sel_n, rd: read_conv,
                      word: word_mode, half: byte_sel};

   sar_ctl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   sar_start_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl_s),
      .start_p (start_p),
      .rd_en   (rd_en)
   );

   sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_p(start_p),
      .half   (ctl_s.half),
      .cmp_hi (cmp_hi),
      .busy   (busy),
      .result (result)
   );

   sar_rd_mux #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_mux (
      .rd_en  (rd_en),
      .word   (ctl_s.word),
      .half   (ctl_s.half),
      .busy   (busy),
      .result (result),
      .dbus   (dbus),
      .dbus_oe(dbus_oe)
   );

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic [RES_W-1:0] dbus,
   input logic [RES_W-1:0] dbus_oe
);

   localparam int CW = $clog2(RES_W + 2);
   localparam logic [RES_W-1:0] HI_OE = {{SHORT_W{1'b1}}, {(RES_W-SHORT_W){1'b0}}};

   logic [CW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + CW'(1);
      else           run_len <= '0;
   end

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= CW'(RES_W));

   // R4
   hidden_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (dbus_oe == '0));

   // R12
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe == '0) |-> (dbus == '0));

   // R12
   lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe == '0) || (dbus_oe == '1) || (dbus_oe == HI_OE));

   // R8
   pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe == HI_OE) |-> ((dbus & ~HI_OE) == '0));

   // R11
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !busy);

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .dbus   (dbus),
   .dbus_oe(dbus_oe)
);

// File: tb/test_sar_bus_ctrl.sv
module test_sar_bus_ctrl;

   localparam int RW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_en = 1'b0, chip_sel_n = 1'b1, read_conv = 1'b1;
   logic          word_mode = 1'b1, byte_sel = 1'b0, cmp_hi = 1'b0;
   logic          busy;
   logic [RW-1:0] dbus, dbus_oe;

   int vectors = 0, fails = 0, k = 0, meas_len = 0;
   logic [RW-1:0] tgt = '0;
   bit done = 0;

   always #10 clk = ~clk;

   sar_bus_ctrl i_sar_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
      .read_conv(read_conv), .word_mode(word_mode), .byte_sel(byte_sel),
      .cmp_hi(cmp_hi), .busy(busy), .dbus(dbus), .dbus_oe(dbus_oe)
   );

   // comparator model: answers the trial bits from the target code, MSB first
   always @(negedge clk) begin
      if (busy) begin
         cmp_hi <= (k < RW) ? tgt[RW-1-k] : 1'b0;
         k      <= k + 1;
      end else if (k > 0) begin
         meas_len <= k;
         k        <= 0;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   task automatic read_views(input logic [RW-1:0] res);
      read_conv = 1'b1; word_mode = 1'b1; cyc(4);
      chk("R7 oe", 32'(dbus_oe), 32'hFFF);
      chk("R7 data", 32'(dbus), 32'(res));
      word_mode = 1'b0; byte_sel = 1'b0; cyc(4);
      chk("R8 oe", 32'(dbus_oe), 32'hFF0);
      chk("R8 data", 32'(dbus), 32'(res & 12'hFF0));
      byte_sel = 1'b1; cyc(4);
      chk("R9 oe", 32'(dbus_oe), 32'hFF0);
      chk("R9 data", 32'(dbus), 32'({res[3:0], 8'h00}));
      word_mode = 1'b1; byte_sel = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      cyc(3);
      chk("R11 busy in reset", 32'(busy), 0);
      chk("R12 oe in reset", 32'(dbus_oe), 0);
      rst_n = 1'b1;
      chip_en = 1'b1; chip_sel_n = 1'b0; read_conv = 1'b1; word_mode = 1'b1;
      cyc(5);
      chk("R11 result after reset", 32'(dbus), 0);
      chk("R11 oe after reset", 32'(dbus_oe), 32'hFFF);

      // R1 R10: every transition between states of the three start lines
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            logic ca, cb;
            ca = (a == 3'b100); cb = (b == 3'b100);
            {chip_en, chip_sel_n, read_conv} = 3'(a);
            cyc(20);
            {chip_en, chip_sel_n, read_conv} = 3'(b);
            cyc(4);
            chk($sformatf("R1 R10 start %0d->%0d", a, b), 32'(busy), 32'(cb && !ca));
            if (!cb) chk("R10 no drive", 32'(dbus_oe != '0 && (b[2:1] != 2'b10)), 0);
            cyc(16);
         end
      end

      // R3 R6 R2 R7 R8 R9 across target codes and both lengths
      chip_en = 1'b1; chip_sel_n = 1'b0; read_conv = 1'b1;
      for (int t = 0; t < 12; t++) begin
         for (int h = 0; h < 2; h++) begin
            logic [RW-1:0] code, res;
            code = (t == 0) ? 12'h000 : (t == 1) ? 12'hFFF : 12'((t * 1447 + 91) % 4096);
            res  = h ? (code & 12'hFF0) : code;
            tgt = code; byte_sel = h[0];
            cyc(1);
            read_conv = 1'b0;
            cyc(22);
            chk("R3 busy length", 32'(meas_len), h ? 8 : 12);
            chk("R2 held start", 32'(busy), 0);
            read_views(res);
         end
      end

      // R5 R4: late start switches 12 -> 8
      tgt = 12'hA5C; byte_sel = 1'b0; read_conv = 1'b0;
      cyc(4);
      read_conv = 1'b1; byte_sel = 1'b1;
      cyc(2);
      chk("R4 hidden while busy", 32'(dbus_oe), 0);
      chk("R5 still busy", 32'(busy), 1);
      read_conv = 1'b0;
      cyc(20);
      chk("R5 shortened length", 32'(meas_len), 8);
      read_views(12'hA50);

      // R5: late start switches 8 -> 12
      tgt = 12'h3C9; byte_sel = 1'b1; read_conv = 1'b0;
      cyc(4);
      read_conv = 1'b1; byte_sel = 1'b0;
      cyc(2);
      chk("R4 hidden while busy", 32'(dbus_oe), 0);
      read_conv = 1'b0;
      cyc(20);
      chk("R5 extended length", 32'(meas_len), 12);
      read_views(12'h3C9);

      // R10: deselected reads
      chip_en = 1'b0; cyc(4);
      chk("R10 ce low oe", 32'(dbus_oe), 0);
      chk("R12 ce low data", 32'(dbus), 0);
      chip_en = 1'b1; chip_sel_n = 1'b1; cyc(4);
      chk("R10 cs high oe", 32'(dbus_oe), 0);

      // R11: reset clears the stored result
      chip_sel_n = 1'b0;
      rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
      chk("R11 cleared result", 32'(dbus), 0);
      chk("R11 idle", 32'(busy), 0);

      finish_run();
   end

endmodule